// File: doc/BRIEF.md
# Miss-Token Sleep Window Controller

This block decides when a core that is stalled on memory can be power-gated, and when it must wake so that it is running again by the time the data comes back. The cache controllers send it a token for each miss. A token names the cache level that missed and gives the number of cycles until the reply is expected. The block keeps up to four outstanding requests. Each request counts its own estimate down. The earliest estimate among them bounds the stall window.

When the core is stalled and the window is long enough to cover the break-even time, the worst wake-up latency, the pipeline refill and a round trip to the wake-up controller, the block asks that controller for a wake-up mode. The answer carries a mode code and that mode's wake-up latency in cycles. The block gates the core only if the window still beats break-even plus that latency plus the refill. Wake-up starts when the cycles left to the earliest arrival equal the mode latency plus the refill. A new miss token that is due sooner than the current window forces an immediate wake-up.

Top module: `sleep_window_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pg_sleep`, `pg_waking`, `mode_req`, `core_idle`, `wake_mode` and `win_level` are all 0.
- R2: A token (`tok_valid`=1) with nonzero `tok_eta` occupies the lowest-numbered free slot of four. Each occupied slot counts down by one per cycle and is freed at the edge where its count reaches zero. A token with `tok_eta`=0, or one that arrives while all four slots are occupied, is dropped and has no effect on the window.
- R3: `win_level` shows the cache level of the occupied slot with the smallest remaining count, the lowest slot index winning a tie. It is 0 when no slot is occupied.
- R4: In the active state, if `core_stall` is 1, some slot is occupied and the window exceeds 111 cycles (57 break-even + 7 refill + 30 worst wake + 17 round trip), then `mode_req` is high from the next cycle. It stays high until a cycle with `mode_rsp_valid`=1.
- R5: On `mode_rsp_valid` while `mode_req` is high, the core is gated (`pg_sleep` high from the next cycle, `wake_mode` takes `mode_rsp_mode`) only if `core_stall` is 1 and the window exceeds `mode_rsp_lat`+64. Otherwise the block returns to active and `wake_mode` keeps its old value.
- R6: While gated, once the window is at most latency+7, or no slot is occupied, `pg_sleep` falls and `pg_waking` is high for exactly latency+7 cycles. The block is then active in the same cycle that the earliest request retires.
- R7: While gated, a token with nonzero `tok_eta` below the current window starts the wake-up of R6 at once.
- R8: `core_idle` equals `core_stall` delayed by one cycle.
- R9: `mode_rsp_valid` is ignored when no request is outstanding: it never causes gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_stall | input | 1 | Core is stalled on memory |
| tok_valid | input | 1 | Miss token present |
| tok_level | input | 2 | Cache level of the miss |
| tok_eta | input | 12 | Cycles until the reply is expected |
| mode_req | output | 1 | Wake-up mode request to the wake-up controller |
| core_idle | output | 1 | Registered idle state reported to the wake-up controller |
| mode_rsp_valid | input | 1 | Mode response present |
| mode_rsp_mode | input | 2 | Granted wake-up mode code |
| mode_rsp_lat | input | 6 | Wake-up latency of the granted mode in cycles |
| pg_sleep | output | 1 | Core held power-gated |
| pg_waking | output | 1 | Wake-up and refill in progress |
| wake_mode | output | 2 | Mode used for the current or last gating |
| win_level | output | 2 | Cache level of the request bounding the window |

## Verification
The hardest situation to reach is a window that shrinks after the core is already gated. A later token must undercut the earliest outstanding estimate while the block sits in the gated state, well away from the normal wake point. The stimulus first gates the core on a long 500-cycle miss with a fast controller reply. It then waits inside the gated period and injects a 50-cycle token. Two other cases need some setup. For the dropped token, the four slots are first filled with long misses, so the short token that follows must be ignored. For the aborted gating, the controller returns a mode latency too large for the remaining window.

// File: rtl/sleep_window_ctrl.sv
module sleep_window_ctrl #(
  parameter int SLOTS      = 4,
  parameter int ETA_W      = 12,
  parameter int LVL_W      = 2,
  parameter int MODE_W     = 2,
  parameter int LAT_W      = 6,
  parameter int BREAK_EVEN = 57,
  parameter int REFILL     = 7,
  parameter int WAKE_MAX   = 30,
  parameter int WUC_RT     = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_stall,
  input  logic              tok_valid,
  input  logic [LVL_W-1:0]  tok_level,
  input  logic [ETA_W-1:0]  tok_eta,
  output logic              mode_req,
  output logic              core_idle,
  input  logic              mode_rsp_valid,
  input  logic [MODE_W-1:0] mode_rsp_mode,
  input  logic [LAT_W-1:0]  mode_rsp_lat,
  output logic              pg_sleep,
  output logic              pg_waking,
  output logic [MODE_W-1:0] wake_mode,
  output logic [LVL_W-1:0]  win_level
);
  localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int XW     = ETA_W + 1;
  localparam int REQ_TH = BREAK_EVEN + REFILL + WAKE_MAX + WUC_RT;

  typedef enum logic [1:0] {ST_RUN, ST_ASK, ST_GATED, ST_WAKE} st_t;

  st_t               st;
  logic              vld [SLOTS];
  logic [ETA_W-1:0]  rem [SLOTS];
  logic [LVL_W-1:0]  lvl [SLOTS];
  logic [LAT_W-1:0]  lat_q;
  logic [XW-1:0]     wcnt;

  logic              any, full, take, early;
  logic [ETA_W-1:0]  win;
  logic [LVL_W-1:0]  wlv;
  logic [SW-1:0]     fidx;
  logic [XW-1:0]     win_x, rsp_need, held_need;

  always_comb begin
    any = 1'b0;
    win = '1;
    wlv = '0;
    for (int i = 0; i < SLOTS; i++)
      if (vld[i] && (!any || rem[i] < win)) begin
        any = 1'b1;
        win = rem[i];
        wlv = lvl[i];
      end
  end

  always_comb begin
    full = 1'b1;
    fidx = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!vld[i]) begin
        full = 1'b0;
        fidx = SW'(i);
      end
  end

  assign take      = tok_valid && (tok_eta != '0) && !full;
  assign early     = tok_valid && (tok_eta != '0) && (tok_eta < win);
  assign win_x     = {1'b0, win};
  assign rsp_need  = XW'(mode_rsp_lat) + XW'(REFILL) + XW'(BREAK_EVEN);
  assign held_need = XW'(lat_q) + XW'(REFILL);

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (rst) begin
        vld[i] <= 1'b0;
        rem[i] <= '0;
        lvl[i] <= '0;
      end else begin
        if (vld[i]) begin
          if (rem[i] == ETA_W'(1)) vld[i] <= 1'b0;
          rem[i] <= rem[i] - ETA_W'(1);
        end
        if (take && fidx == SW'(i)) begin
          vld[i] <= 1'b1;
          rem[i] <= tok_eta;
          lvl[i] <= tok_level;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RUN;
      lat_q     <= '0;
      wake_mode <= '0;
      wcnt      <= '0;
      core_idle <= 1'b0;
    end else begin
      core_idle <= core_stall;
      case (st)
        ST_RUN:
          if (core_stall && any && win_x > XW'(REQ_TH)) st <= ST_ASK;
        ST_ASK:
          if (mode_rsp_valid) begin
            if (core_stall && any && win_x > rsp_need) begin
              st        <= ST_GATED;
              lat_q     <= mode_rsp_lat;
              wake_mode <= mode_rsp_mode;
            end else begin
              st <= ST_RUN;
            end
          end
        ST_GATED:
          if (early || !any || win_x <= held_need) begin
            st   <= ST_WAKE;
            wcnt <= held_need;
          end
        default:
          if (wcnt <= XW'(1)) st <= ST_RUN;
          else wcnt <= wcnt - XW'(1);
      endcase
    end
  end

  assign mode_req  = (st == ST_ASK);
  assign pg_sleep  = (st == ST_GATED);
  assign pg_waking = (st == ST_WAKE);
  assign win_level = any ? wlv : '0;
endmodule

// File: rtl/sleep_window_ctrl_chk.sv
module sleep_window_ctrl_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              core_stall,
  input logic              mode_req,
  input logic              mode_rsp_valid,
  input logic              core_idle,
  input logic              pg_sleep,
  input logic              pg_waking,
  input logic [MODE_W-1:0] wake_mode
);
  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    mode_req && !mode_rsp_valid |=> mode_req);

  assert_sleep_entry_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pg_sleep) |-> $past(mode_req && mode_rsp_valid));

  assert_mode_steady_R5: assert property (@(posedge clk) disable iff (rst)
    pg_sleep && $past(pg_sleep) |-> $stable(wake_mode));

  assert_wake_after_sleep_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(pg_sleep) |-> pg_waking);

  assert_idle_follow_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> core_idle == $past(core_stall));

  assert_stray_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    mode_rsp_valid && !mode_req && !pg_sleep && !pg_waking |=> !pg_sleep);
endmodule

bind sleep_window_ctrl sleep_window_ctrl_chk #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst(rst), .core_stall(core_stall), .mode_req(mode_req),
  .mode_rsp_valid(mode_rsp_valid), .core_idle(core_idle),
  .pg_sleep(pg_sleep), .pg_waking(pg_waking), .wake_mode(wake_mode)
);

// File: tb/sleep_window_ctrl_bench.sv
module sleep_window_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic core_stall = 0, tok_valid = 0, mode_rsp_valid = 0;
  logic [1:0] tok_level = '0, mode_rsp_mode = '0;
  logic [11:0] tok_eta = '0;
  logic [5:0] mode_rsp_lat = '0;
  logic mode_req, core_idle, pg_sleep, pg_waking;
  logic [1:0] wake_mode, win_level;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_window_ctrl u_sleep_window_ctrl (
    .clk(clk), .rst(rst), .core_stall(core_stall), .tok_valid(tok_valid),
    .tok_level(tok_level), .tok_eta(tok_eta), .mode_req(mode_req),
    .core_idle(core_idle), .mode_rsp_valid(mode_rsp_valid),
    .mode_rsp_mode(mode_rsp_mode), .mode_rsp_lat(mode_rsp_lat),
    .pg_sleep(pg_sleep), .pg_waking(pg_waking), .wake_mode(wake_mode),
    .win_level(win_level)
  );

  int checks = 0, fails = 0;
  int m_v[4], m_r[4], m_l[4];
  int m_st = 0, m_lat = 0, m_mode = 0, m_w = 0, m_idle = 0;
  int wuc_dly = 3, wuc_lat = 20, wuc_mode = 2, req_age = 0;
  bit force_rsp = 0;
  bit saw_req, saw_sleep, prev_wk;
  int wake_cnt, lvl_at_fall;
  int s_wk;

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_lvl();
    int win = 4095, lv = 0;
    bit any = 0;
    for (int i = 0; i < 4; i++)
      if (m_v[i] != 0 && (!any || m_r[i] < win)) begin any = 1; win = m_r[i]; lv = m_l[i]; end
    return lv;
  endfunction

  function automatic void mdl(bit st, bit tv, int tl, int te, bit rv, int rm, int rl);
    int win = 4095, fidx = -1;
    bit any = 0;
    for (int i = 0; i < 4; i++)
      if (m_v[i] != 0 && (!any || m_r[i] < win)) begin any = 1; win = m_r[i]; end
    for (int i = 3; i >= 0; i--) if (m_v[i] == 0) fidx = i;
    case (m_st)
      0: if (st && any && win > 111) m_st = 1;
      1: if (rv) begin
           if (st && any && win > rl + 64) begin m_st = 2; m_lat = rl; m_mode = rm; end
           else m_st = 0;
         end
      2: if ((tv && te != 0 && te < win) || !any || win <= m_lat + 7) begin
           m_st = 3; m_w = m_lat + 7;
         end
      default: if (m_w <= 1) m_st = 0; else m_w--;
    endcase
    for (int i = 0; i < 4; i++)
      if (m_v[i] != 0) begin
        if (m_r[i] == 1) m_v[i] = 0;
        m_r[i]--;
      end
    if (tv && te != 0 && fidx >= 0) begin m_v[fidx] = 1; m_r[fidx] = te; m_l[fidx] = tl; end
    m_idle = st;
  endfunction

  task automatic step(bit st, bit tv = 0, int tl = 0, int te = 0);
    bit rv;
    @(negedge clk);
    cmp("R4 mode_req", mode_req, m_st == 1);
    cmp("R5 pg_sleep", pg_sleep, m_st == 2);
    cmp("R6 pg_waking", pg_waking, m_st == 3);
    cmp("R5 wake_mode", wake_mode, m_mode);
    cmp("R3 win_level", win_level, exp_lvl());
    cmp("R8 core_idle", core_idle, m_idle);
    if (mode_req) saw_req = 1;
    if (pg_sleep) saw_sleep = 1;
    if (pg_waking) wake_cnt++;
    if (prev_wk && !pg_waking) lvl_at_fall = win_level;
    prev_wk = pg_waking;
    s_wk = pg_waking;
    rv = force_rsp || (m_st == 1 && req_age >= wuc_dly);
    core_stall = st; tok_valid = tv; tok_level = tl[1:0]; tok_eta = te[11:0];
    mode_rsp_valid = rv; mode_rsp_mode = wuc_mode[1:0]; mode_rsp_lat = wuc_lat[5:0];
    mdl(st, tv, tl, te, rv, wuc_mode, wuc_lat);
    req_age = (m_st == 1) ? req_age + 1 : 0;
  endtask

  task automatic clear_flags();
    saw_req = 0; saw_sleep = 0; wake_cnt = 0; lvl_at_fall = -1; prev_wk = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((m_v[0] + m_v[1] + m_v[2] + m_v[3] != 0 || m_st != 0) && guard < 5000) begin
      step(0); guard++;
    end
    step(0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_r[i] = 0; m_l[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 pg_sleep", pg_sleep, 0); cmp("R1 pg_waking", pg_waking, 0);
    cmp("R1 mode_req", mode_req, 0); cmp("R1 core_idle", core_idle, 0);
    cmp("R1 wake_mode", wake_mode, 0); cmp("R1 win_level", win_level, 0);
    rst = 0;
    step(0);
    cmp("R1 first cycle pg_sleep", pg_sleep, 0);

    // R3: level of earliest request
    step(0, 1, 2, 300); step(0, 1, 1, 200); step(0);
    cmp("R3 earliest level", win_level, 1);
    drain();
    cmp("R3 empty level", win_level, 0);

    // R2: zero estimate dropped
    step(0, 1, 3, 0); step(0);
    cmp("R2 zero eta dropped", win_level, 0);

    // R4 boundary: 111 does not request, 112 does; R5 abort with slow mode
    clear_flags();
    step(1, 1, 1, 111);
    repeat (120) step(1);
    cmp("R4 window 111 no request", saw_req, 0);
    drain();
    clear_flags(); wuc_lat = 60; wuc_mode = 1;
    step(1, 1, 1, 112);
    repeat (20) step(1);
    cmp("R4 window 112 requests", saw_req, 1);
    cmp("R5 abort on slow mode", saw_sleep, 0);
    cmp("R5 mode kept on abort", wake_mode, 0);
    drain();

    // R5/R6: normal gating and timed wake
    clear_flags(); wuc_lat = 20; wuc_mode = 2;
    step(1, 1, 3, 400);
    repeat (420) step(1);
    cmp("R5 gated", saw_sleep, 1);
    cmp("R5 mode latched", wake_mode, 2);
    cmp("R6 waking length", wake_cnt, 27);
    cmp("R6 ready at arrival", lvl_at_fall, 0);
    drain();

    // R7: earlier token while gated forces wake
    clear_flags(); wuc_lat = 25; wuc_mode = 3;
    step(1, 1, 2, 500);
    repeat (40) step(1);
    cmp("R7 gated before token", pg_sleep, 1);
    step(1, 1, 1, 50);
    step(1);
    cmp("R7 forced wake", s_wk, 1);
    repeat (10) step(1);
    drain();

    // R2: full slots drop a short token
    clear_flags();
    for (int i = 0; i < 4; i++) step(0, 1, 2, 600);
    step(0, 1, 1, 30);
    step(1);
    step(1);
    cmp("R2 dropped short token", saw_req, 1);
    cmp("R2 dropped level", win_level, 2);
    drain();

    // R9: stray response
    clear_flags(); force_rsp = 1;
    repeat (5) step(1);
    force_rsp = 0;
    step(0); step(0);
    cmp("R9 stray response", saw_sleep, 0);

    // R8: idle tracking
    step(1); step(0);
    cmp("R8 idle tracks stall", core_idle, 1);
    step(0);
    cmp("R8 idle clears", core_idle, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule